// File: doc/BRIEF.md
# Power-Up Configuration Record Loader

This block runs once after every reset. It pulls an eight-byte configuration record out of a serial EEPROM and turns it into the identification and attribute values that the USB device descriptors use. The record is read one byte at a time through a simple request/response port that an I2C master serves. The master does the bit-level bus work, and this block never touches the bus wires itself. Every byte goes into a shadow copy first. The visible outputs change in one step, and only after the whole record has arrived and its signature byte checks out.

If the record is missing, corrupt or unreadable, the block falls back to fixed identifiers. The two bus lines are sampled as straps on the first cycle after reset, and these two levels then choose remote-wakeup support and the power source. In both cases a single-cycle completion strobe marks the cycle in which the outputs become final.

Top module: `cfg_boot_loader`

## Requirements
- R1: While reset is held, the block drives these values: `rd_req`=0, `done`=0, `vendor_id`=0x04E2, `product_id`=0x1410, `attr`=0x00, `max_power`=0x00, `wakeup_en`=0, `bus_powered`=0 and `from_eeprom`=0.
- R2: The block captures `strap_sda` and `strap_scl` on the first clock edge after reset is released. Any later change on these pins has no effect on the result.
- R3: The block issues reads for offsets 0, 1, 2 and so on up to 7, in ascending order, with `rd_dev`=0xA0. Each request is a single-cycle `rd_req`, and no new request starts until the previous one has received `rd_valid` or `rd_err`.
- R4: If byte 7 equals 0x58 and no error occurred, the outputs are loaded from the record. `vendor_id` = {byte1, byte0} and `product_id` = {byte3, byte2}. `attr` = byte4 and `max_power` = byte5, and `from_eeprom`=1. `wakeup_en` = `attr` bit 5 and `bus_powered` = NOT `attr` bit 6.
- R5: If byte 7 is not 0x58, the record is ignored and the fallback values are used. These are `vendor_id`=0x04E2, `product_id`=0x1410, `max_power`=0x32 and `from_eeprom`=0. The sampled straps decide the two flags: `wakeup_en` = NOT sda and `bus_powered` = NOT scl, so (sda, scl) = 11 gives no wakeup and self-powered, 10 gives no wakeup and bus-powered, 01 gives wakeup and self-powered, and 00 gives wakeup and bus-powered. `attr` = 0x80, plus 0x40 when self-powered, plus 0x20 when wakeup is set.
- R6: An `rd_err` response stops the read sequence. No further request follows it, and the outputs take the R5 fallback values.
- R7: `done` is high for exactly one cycle per reset. It rises in the same cycle that the outputs take their final values, and the outputs do not change in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_sda | input | 1 | Data-line level, sampled once as a strap |
| strap_scl | input | 1 | Clock-line level, sampled once as a strap |
| rd_req | output | 1 | Single-cycle byte-read request to the I2C master |
| rd_dev | output | 8 | EEPROM device address for the request |
| rd_addr | output | 3 | Record offset requested |
| rd_valid | input | 1 | Read data is valid |
| rd_data | input | 8 | Returned byte |
| rd_err | input | 1 | Master reports a NACK or bus error |
| vendor_id | output | 16 | Vendor identifier |
| product_id | output | 16 | Product identifier |
| attr | output | 8 | Configuration attributes byte |
| max_power | output | 8 | Maximum power byte |
| wakeup_en | output | 1 | Remote wakeup supported |
| bus_powered | output | 1 | Device draws power from the bus |
| from_eeprom | output | 1 | Outputs came from a valid record |
| done | output | 1 | One-cycle strobe when outputs become final |

## Verification
A wrong read index or a lost response shows up at once on `rd_addr`, because the offset would jump or repeat. It also shows up as a request count that does not match what the responder model expects when `done` fires. If the commit decision is wrong, for example a stale abort flag or a bad signature compare, every output field is wrong in the one cycle where `done` is high. The straps are flipped just after they are sampled, so a sampler that captures late flips the fallback flags. A commit that leaks early changes an output before `done`, and the bench checks for this at a fixed point during the read sequence.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam logic [7:0]  DEV_ADDR   = 8'hA0;
  localparam logic [7:0]  SIG_BYTE   = 8'h58;
  localparam logic [15:0] DEF_VID    = 16'h04E2;
  localparam logic [15:0] DEF_PID    = 16'h1410;
  localparam logic [7:0]  DEF_MAXPWR = 8'h32;

  localparam int unsigned OFS_VID_LO = 0;
  localparam int unsigned OFS_VID_HI = 1;
  localparam int unsigned OFS_PID_LO = 2;
  localparam int unsigned OFS_PID_HI = 3;
  localparam int unsigned OFS_ATTR   = 4;
  localparam int unsigned OFS_PWR    = 5;
  localparam int unsigned OFS_SIG    = 7;

  typedef enum logic [2:0] {
    ST_STRAP, ST_REQ, ST_WAIT, ST_EVAL, ST_FIN
  } ld_state_t;

  // Attribute byte built for the fallback path: bit7 always set,
  // bit6 self-powered, bit5 remote wakeup.
  function automatic logic [7:0] fallback_attr(input logic wake, input logic bus);
    return {1'b1, ~bus, wake, 5'b00000};
  endfunction

  function automatic logic attr_wake(input logic [7:0] a);
    return a[5];
  endfunction

  function automatic logic attr_bus(input logic [7:0] a);
    return ~a[6];
  endfunction

  // Strap decode: a low data line enables wakeup, a low clock line
  // selects bus power.
  function automatic logic strap_wake(input logic sda);
    return ~sda;
  endfunction

  function automatic logic strap_bus(input logic scl);
    return ~scl;
  endfunction
endpackage

// File: rtl/cfgld_strap.sv
module cfgld_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic sda,
  input  logic scl,
  output logic wake,
  output logic bus
);
  import cfgld_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake <= 1'b0;
      bus  <= 1'b0;
    end else if (sample) begin
      wake <= strap_wake(sda);
      bus  <= strap_bus(scl);
    end
  end
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq #(
  parameter int unsigned REC_BYTES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_valid,
  input  logic                         rd_err,
  output logic                         rd_req,
  output logic [$clog2(REC_BYTES)-1:0] rd_addr,
  output logic                         samp_pulse,
  output logic                         cap_fire,
  output logic                         eval_fire,
  output logic                         aborted
);
  import cfgld_pkg::*;
  localparam int unsigned IDX_W = $clog2(REC_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);

  ld_state_t        st;
  logic [IDX_W-1:0] idx;
  logic             last_byte;

  assign last_byte  = (idx == LAST_IDX);
  assign rd_req     = (st == ST_REQ);
  assign rd_addr    = idx;
  assign samp_pulse = (st == ST_STRAP);
  // An error wins over data arriving in the same cycle.
  assign cap_fire   = (st == ST_WAIT) && rd_valid && !rd_err;
  assign eval_fire  = (st == ST_EVAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_STRAP;
      idx     <= '0;
      aborted <= 1'b0;
    end else begin
      case (st)
        ST_STRAP: st <= ST_REQ;
        ST_REQ:   st <= ST_WAIT;
        ST_WAIT: begin
          if (rd_err) begin
            aborted <= 1'b1;
            st      <= ST_EVAL;
          end else if (rd_valid) begin
            if (last_byte) begin
              st <= ST_EVAL;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_REQ;
            end
          end
        end
        ST_EVAL: st <= ST_FIN;
        default: st <= st;
      endcase
    end
  end
endmodule

// File: rtl/cfgld_shadow.sv
module cfgld_shadow #(
  parameter int unsigned REC_BYTES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cap,
  input  logic [$clog2(REC_BYTES)-1:0] idx,
  input  logic [7:0]                   data,
  output logic [REC_BYTES*8-1:0]       rec
);
  localparam int unsigned IDX_W = $clog2(REC_BYTES);

  for (genvar b = 0; b < REC_BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rec[b*8 +: 8] <= 8'h00;
      end else if (cap && (idx == IDX_W'(b))) begin
        rec[b*8 +: 8] <= data;
      end
    end
  end
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader #(
  parameter int unsigned REC_BYTES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         strap_sda,
  input  logic                         strap_scl,
  output logic                         rd_req,
  output logic [7:0]                   rd_dev,
  output logic [$clog2(REC_BYTES)-1:0] rd_addr,
  input  logic                         rd_valid,
  input  logic [7:0]                   rd_data,
  input  logic                         rd_err,
  output logic [15:0]                  vendor_id,
  output logic [15:0]                  product_id,
  output logic [7:0]                   attr,
  output logic [7:0]                   max_power,
  output logic                         wakeup_en,
  output logic                         bus_powered,
  output logic                         from_eeprom,
  output logic                         done
);
  import cfgld_pkg::*;

  logic                   samp_pulse, cap_fire, eval_fire, aborted;
  logic                   s_wake, s_bus;
  logic [REC_BYTES*8-1:0] rec;
  logic                   rec_ok;
  logic [7:0]             rec_attr;

  assign rd_dev = DEV_ADDR;

  cfgld_strap u_strap (
    .clk(clk), .rst_n(rst_n), .sample(samp_pulse),
    .sda(strap_sda), .scl(strap_scl), .wake(s_wake), .bus(s_bus)
  );

  cfgld_seq #(.REC_BYTES(REC_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_err(rd_err),
    .rd_req(rd_req), .rd_addr(rd_addr), .samp_pulse(samp_pulse),
    .cap_fire(cap_fire), .eval_fire(eval_fire), .aborted(aborted)
  );

  cfgld_shadow #(.REC_BYTES(REC_BYTES)) u_shadow (
    .clk(clk), .rst_n(rst_n), .cap(cap_fire), .idx(rd_addr),
    .data(rd_data), .rec(rec)
  );

  assign rec_attr = rec[OFS_ATTR*8 +: 8];
  assign rec_ok   = !aborted && (rec[OFS_SIG*8 +: 8] == SIG_BYTE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vendor_id   <= DEF_VID;
      product_id  <= DEF_PID;
      attr        <= 8'h00;
      max_power   <= 8'h00;
      wakeup_en   <= 1'b0;
      bus_powered <= 1'b0;
      from_eeprom <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= eval_fire;
      if (eval_fire) begin
        if (rec_ok) begin
          vendor_id   <= {rec[OFS_VID_HI*8 +: 8], rec[OFS_VID_LO*8 +: 8]};
          product_id  <= {rec[OFS_PID_HI*8 +: 8], rec[OFS_PID_LO*8 +: 8]};
          attr        <= rec_attr;
          max_power   <= rec[OFS_PWR*8 +: 8];
          wakeup_en   <= attr_wake(rec_attr);
          bus_powered <= attr_bus(rec_attr);
          from_eeprom <= 1'b1;
        end else begin
          vendor_id   <= DEF_VID;
          product_id  <= DEF_PID;
          attr        <= fallback_attr(s_wake, s_bus);
          max_power   <= DEF_MAXPWR;
          wakeup_en   <= s_wake;
          bus_powered <= s_bus;
          from_eeprom <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
  parameter int unsigned REC_BYTES = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         rd_req,
  input logic [$clog2(REC_BYTES)-1:0] rd_addr,
  input logic                         rd_valid,
  input logic                         rd_err,
  input logic [15:0]                  vendor_id,
  input logic [15:0]                  product_id,
  input logic [7:0]                   attr,
  input logic [7:0]                   max_power,
  input logic                         wakeup_en,
  input logic                         bus_powered,
  input logic                         from_eeprom,
  input logic                         done
);
  localparam int unsigned IDX_W = $clog2(REC_BYTES);

  logic             done_seen, outst, err_seen;
  logic [IDX_W:0]   nreq;
  logic [53:0]      out_bus;

  assign out_bus = {vendor_id, product_id, attr, max_power,
                    wakeup_en, bus_powered, from_eeprom, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_seen <= 1'b0;
      outst     <= 1'b0;
      err_seen  <= 1'b0;
      nreq      <= '0;
    end else begin
      if (done) done_seen <= 1'b1;
      if (rd_req) begin
        outst <= 1'b1;
        nreq  <= nreq + 1'b1;
      end else if (rd_valid || rd_err) begin
        outst <= 1'b0;
      end
      if (outst && rd_err) err_seen <= 1'b1;
    end
  end

  // R7: completion strobe lasts one cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: only one completion per reset
  assert_done_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_seen |-> !done);

  // R7: outputs move only in the completion cycle
  assert_outputs_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_bus) |-> done);

  // R3: a request is never followed directly by another
  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R3: offsets requested in ascending order from zero
  assert_req_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ({1'b0, rd_addr} == nreq));

  // R6: no traffic after an error response
  assert_abort_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen |-> !rd_req);

  // R4: flags follow the loaded attribute byte
  assert_eeprom_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    from_eeprom |-> (wakeup_en == attr[5]) && (bus_powered == !attr[6]));
endmodule

bind cfg_boot_loader cfgld_chk #(.REC_BYTES(REC_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .rd_err(rd_err), .vendor_id(vendor_id),
  .product_id(product_id), .attr(attr), .max_power(max_power),
  .wakeup_en(wakeup_en), .bus_powered(bus_powered),
  .from_eeprom(from_eeprom), .done(done)
);

// File: tb/cfg_boot_loader_tb.sv
module cfg_boot_loader_tb;
  localparam int LAT = 2;

  typedef struct {
    logic [15:0] vid;
    logic [15:0] pid;
    logic [7:0]  attr;
    logic [7:0]  pwr;
    logic        wake;
    logic        bus;
    logic        fe;
    int          nreq;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_sda = 1'b1, strap_scl = 1'b1;
  logic        rd_req;
  logic [7:0]  rd_dev;
  logic [2:0]  rd_addr;
  logic        rd_valid = 1'b0, rd_err = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic [15:0] vendor_id, product_id;
  logic [7:0]  attr, max_power;
  logic        wakeup_en, bus_powered, from_eeprom, done;

  int   checks = 0, failures = 0;
  int   done_cnt = 0, nreq_seen = 0, err_at = -1;
  logic [7:0] mem [8];
  exp_t exp_q[$];
  exp_t last_exp;

  always #5 clk = ~clk;

  cfg_boot_loader u_dut (
    .clk(clk), .rst_n(rst_n), .strap_sda(strap_sda), .strap_scl(strap_scl),
    .rd_req(rd_req), .rd_dev(rd_dev), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err),
    .vendor_id(vendor_id), .product_id(product_id), .attr(attr),
    .max_power(max_power), .wakeup_en(wakeup_en), .bus_powered(bus_powered),
    .from_eeprom(from_eeprom), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_outputs(input exp_t e, input string req);
    chk(vendor_id == e.vid, req, "vendor_id", vendor_id, e.vid);
    chk(product_id == e.pid, req, "product_id", product_id, e.pid);
    chk(attr == e.attr, req, "attr", attr, e.attr);
    chk(max_power == e.pwr, req, "max_power", max_power, e.pwr);
    chk(wakeup_en == e.wake, req, "wakeup_en", wakeup_en, e.wake);
    chk(bus_powered == e.bus, req, "bus_powered", bus_powered, e.bus);
    chk(from_eeprom == e.fe, req, "from_eeprom", from_eeprom, e.fe);
  endtask

  // Responder model of the I2C master, checks request order (R3)
  initial begin
    int pend = 0;
    int cur = 0;
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      rd_err   = 1'b0;
      if (!rst_n) begin
        pend = 0;
      end else begin
        if (pend > 0) begin
          pend--;
          if (pend == 0) begin
            if (cur == err_at) rd_err = 1'b1;
            else begin
              rd_valid = 1'b1;
              rd_data  = mem[cur];
            end
          end
        end
        if (rd_req) begin
          chk(pend == 0, "R3", "request while outstanding", 32'(pend), 0);
          chk(int'(rd_addr) == nreq_seen, "R3", "rd_addr order", 32'(rd_addr), 32'(nreq_seen));
          chk(rd_dev == 8'hA0, "R3", "rd_dev", rd_dev, 8'hA0);
          cur  = int'(rd_addr);
          pend = LAT;
          nreq_seen++;
        end
      end
    end
  end

  // Monitor: pops expected results when the completion strobe fires
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "extra done pulse", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          last_exp = e;
          cmp_outputs(e, e.fe ? "R4" : (e.nreq < 8 ? "R6" : "R5"));
          chk(nreq_seen == e.nreq, e.nreq < 8 ? "R6" : "R3", "request count",
              32'(nreq_seen), 32'(e.nreq));
          done_cnt++;
        end
      end
    end
  end

  task automatic run_case(input logic [15:0] vid, input logic [15:0] pid,
                          input logic [7:0] at, input logic [7:0] pw,
                          input logic [7:0] sig, input int eat,
                          input logic sda, input logic scl);
    exp_t e;
    exp_t rv;
    int   start;
    mem[0] = vid[7:0]; mem[1] = vid[15:8];
    mem[2] = pid[7:0]; mem[3] = pid[15:8];
    mem[4] = at; mem[5] = pw; mem[6] = 8'hEE; mem[7] = sig;
    if (eat < 0 && sig == 8'h58) begin
      e.vid = vid; e.pid = pid; e.attr = at; e.pwr = pw;
      e.wake = at[5]; e.bus = !at[6]; e.fe = 1'b1; e.nreq = 8;
    end else begin
      e.vid = 16'h04E2; e.pid = 16'h1410; e.pwr = 8'h32; e.fe = 1'b0;
      e.wake = (sda == 1'b0);
      e.bus  = (scl == 1'b0);
      e.attr = 8'h80 + (scl ? 8'h40 : 8'h00) + (e.wake ? 8'h20 : 8'h00);
      e.nreq = (eat < 0) ? 8 : eat + 1;
    end
    rv.vid = 16'h04E2; rv.pid = 16'h1410; rv.attr = 8'h00; rv.pwr = 8'h00;
    rv.wake = 1'b0; rv.bus = 1'b0; rv.fe = 1'b0; rv.nreq = 0;

    @(negedge clk);
    rst_n = 1'b0;
    strap_sda = sda;
    strap_scl = scl;
    err_at = eat;
    repeat (3) @(negedge clk);
    nreq_seen = 0;
    cmp_outputs(rv, "R1");
    chk(rd_req == 1'b0 && done == 1'b0, "R1", "rd_req/done in reset", {rd_req, done}, 0);
    exp_q.push_back(e);
    start = done_cnt;
    rst_n = 1'b1;
    @(negedge clk);
    strap_sda = ~sda;  // R2: late strap change must be ignored
    strap_scl = ~scl;
    repeat (2) @(negedge clk);
    cmp_outputs(rv, "R7");
    while (done_cnt == start) @(negedge clk);
    repeat (5) @(negedge clk);
    cmp_outputs(e, "R7");
    chk(done == 1'b0, "R7", "done after pulse", done, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R4: valid records with different attribute bytes
    run_case(16'hBEEF, 16'h1234, 8'hA0, 8'h64, 8'h58, -1, 1'b1, 1'b1);
    run_case(16'h0102, 16'hA5C3, 8'hC0, 8'hFA, 8'h58, -1, 1'b0, 1'b0);
    // R5 / R2: bad signature, all four strap codes
    run_case(16'hBEEF, 16'h1234, 8'hA0, 8'h64, 8'h59, -1, 1'b1, 1'b1);
    run_case(16'hBEEF, 16'h1234, 8'hA0, 8'h64, 8'h00, -1, 1'b1, 1'b0);
    run_case(16'hBEEF, 16'h1234, 8'hA0, 8'h64, 8'hD8, -1, 1'b0, 1'b1);
    run_case(16'hBEEF, 16'h1234, 8'hA0, 8'h64, 8'h85, -1, 1'b0, 1'b0);
    // R6: errors at the middle, last and first offset
    run_case(16'hBEEF, 16'h1234, 8'hA0, 8'h64, 8'h58, 3, 1'b0, 1'b1);
    run_case(16'hBEEF, 16'h1234, 8'hA0, 8'h64, 8'h58, 7, 1'b1, 1'b0);
    run_case(16'hBEEF, 16'h1234, 8'hA0, 8'h64, 8'h58, 0, 1'b0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule